// File: doc/BRIEF.md
# Descriptor Ring Master Control Registers

This block is the register front end of a bus master that works through a ring of descriptors held in system memory. Software programs the ring's base address and its size. It fills descriptors, moves a head pointer forward and sets a start bit. The block keeps its own tail pointer. While the tail trails the head and the run is enabled, it offers the tail index to a downstream transaction engine. It moves the tail forward each time the engine signals that a descriptor has finished.

Completion and error events are latched into sticky status flags that software clears by writing ones. A single level-sensitive interrupt line, which may be shared with other devices, is raised while either flag is set, provided the error interrupt enable is on. Register reads are combinational from the current address. Writes take effect at the next rising clock edge.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset every mapped register reads 0, the engine request is low and the interrupt line is low.
- R2: The 64-bit descriptor base address is written and read as a low word at offset 0x100 and a high word at 0x104. The full value is presented on `eng_base`.
- R3: The control register at 0x108 holds the start bit in bit 0, the error interrupt enable in bit 4 and the software head pointer in bits 23:16. All three read back as written.
- R4: The size register at 0x110 holds the entry count minus one in bits 7:0. A tail that equals this value advances to 0.
- R5: While start is set and the tail differs from the head, `eng_req` is high, `eng_idx` equals the tail, and status bit 0 (in progress) reads 1.
- R6: Each `eng_done` pulse that arrives while `eng_req` is high advances the tail by one, modulo the ring size. The tail is readable in status bits 23:16. A pulse that arrives while `eng_req` is low leaves the tail unchanged.
- R7: When the tail equals the head while start is set, start clears by itself one edge later, and status bit 0 reads 0. This holds both when a completion brings the tail level with the head and when start is written while the pointers are already equal.
- R8: An accepted completion sets the completion flag (status bit 5) when `eng_want_irq` is high. It sets the error flag (status bit 4) when `eng_fail` is high. Both flags stay set until cleared.
- R9: Writing 1 to status bit 5 or bit 4 clears that flag, and writing 0 leaves it unchanged. A flag that is set and cleared on the same edge stays set.
- R10: `irq` is high exactly when the error interrupt enable is 1 and at least one of the two flags is set.
- R11: Writing start to 0 while the ring is running drops `eng_req` at once and keeps the tail. Writing start to 1 again resumes from that tail.
- R12: Any other offset reads 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (12) | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| eng_base | output | BASE_W (64) | Descriptor ring base address for the engine |
| eng_req | output | 1 | A descriptor is ready to be processed |
| eng_idx | output | PTR_W (8) | Index of the descriptor to process (the tail) |
| eng_done | input | 1 | One-cycle pulse: the current descriptor finished |
| eng_want_irq | input | 1 | Finished descriptor asked for a completion interrupt |
| eng_fail | input | 1 | Finished descriptor ended in error |
| irq | output | 1 | Level interrupt line |

## Verification
The bound checker watches invariants on every cycle. The tail never moves without an accepted completion. The tail wraps from the size value to zero. The offered index never equals the head. Start drops after the pointers meet. A cleared flag stays clear unless a new completion arrives, and a set flag stays set until software clears it. The interrupt is never raised without the enable and a pending flag. Only the bench's scenarios can show the end-to-end behaviour: the register layouts and readback values, the full sequence of tail indices across a wrap, pausing and resuming a run, set winning over a same-edge clear, and writes to unmapped offsets having no effect.

// File: rtl/drc_pkg.sv
package drc_pkg;
    // Register byte offsets
    localparam int unsigned OFS_BASE_LO = 32'h100;
    localparam int unsigned OFS_BASE_HI = 32'h104;
    localparam int unsigned OFS_CTRL    = 32'h108;
    localparam int unsigned OFS_STAT    = 32'h10C;
    localparam int unsigned OFS_SIZE    = 32'h110;

    // Field positions
    localparam int unsigned CTRL_RUN_BIT  = 0;
    localparam int unsigned CTRL_EIE_BIT  = 4;
    localparam int unsigned PTR_LSB       = 16;
    localparam int unsigned STAT_BUSY_BIT = 0;
    localparam int unsigned STAT_ERR_BIT  = 4;
    localparam int unsigned STAT_CMP_BIT  = 5;
    localparam int unsigned PTR_FIELD_W   = 8;
endpackage

// File: rtl/drc_cfg_regs.sv
module drc_cfg_regs #(
    parameter int BASE_W = 64,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_base_lo,
    input  logic              wr_base_hi,
    input  logic              wr_ctrl,
    input  logic              wr_size,
    input  logic [31:0]       wdata,
    input  logic              stop_run,
    output logic [BASE_W-1:0] base,
    output logic [PTR_W-1:0]  head,
    output logic [PTR_W-1:0]  size_m1,
    output logic              run,
    output logic              err_ie
);
    import drc_pkg::*;

    localparam int HI_W = BASE_W - 32;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [PTR_W-1:0]  head;
        logic [PTR_W-1:0]  size_m1;
        logic              run;
        logic              err_ie;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_base_lo) begin
            st_d.base[31:0] = wdata;
        end
        if (wr_base_hi) begin
            st_d.base[BASE_W-1:32] = wdata[HI_W-1:0];
        end
        if (wr_size) begin
            st_d.size_m1 = wdata[PTR_W-1:0];
        end
        if (wr_ctrl) begin
            st_d.run    = wdata[CTRL_RUN_BIT];
            st_d.err_ie = wdata[CTRL_EIE_BIT];
            st_d.head   = wdata[PTR_LSB +: PTR_W];
        end else if (stop_run) begin
            st_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base    = st_q.base;
    assign head    = st_q.head;
    assign size_m1 = st_q.size_m1;
    assign run     = st_q.run;
    assign err_ie  = st_q.err_ie;
endmodule

// File: rtl/drc_ring_ptr.sv
module drc_ring_ptr #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PTR_W-1:0] head,
    input  logic [PTR_W-1:0] size_m1,
    input  logic             done,
    output logic [PTR_W-1:0] tail,
    output logic             busy,
    output logic             accept,
    output logic             stop_run
);
    typedef struct packed {
        logic [PTR_W-1:0] tail;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [PTR_W-1:0] tail_inc;

    always_comb begin
        st_d     = st_q;
        busy     = run && (st_q.tail != head);
        accept   = busy && done;
        tail_inc = (st_q.tail == size_m1) ? '0 : st_q.tail + 1'b1;
        if (accept) begin
            st_d.tail = tail_inc;
        end
        // Drain detection uses the tail that will be registered
        stop_run = run && (st_d.tail == head);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tail = st_q.tail;
endmodule

// File: rtl/drc_irq_flags.sv
module drc_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic want_irq,
    input  logic fail,
    input  logic clr_cmp,
    input  logic clr_err,
    input  logic err_ie,
    output logic cmp,
    output logic err,
    output logic irq
);
    typedef struct packed {
        logic cmp;
        logic err;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Clear first so that a new event on the same edge wins
        if (clr_cmp) st_d.cmp = 1'b0;
        if (clr_err) st_d.err = 1'b0;
        if (accept && want_irq) st_d.cmp = 1'b1;
        if (accept && fail)     st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp = st_q.cmp;
    assign err = st_q.err;
    assign irq = err_ie && (st_q.cmp || st_q.err);
endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl #(
    parameter int ADDR_W = 12,
    parameter int BASE_W = 64,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [BASE_W-1:0] eng_base,
    output logic              eng_req,
    output logic [PTR_W-1:0]  eng_idx,
    input  logic              eng_done,
    input  logic              eng_want_irq,
    input  logic              eng_fail,
    output logic              irq
);
    import drc_pkg::*;

    logic sel_lo, sel_hi, sel_ctrl, sel_stat, sel_size;
    logic wr_lo_w, wr_hi_w, wr_ctrl_w, wr_stat_w, wr_size_w;
    logic clr_cmp_w, clr_err_w;
    logic [BASE_W-1:0] base_w;
    logic [PTR_W-1:0]  head_w, size_w, tail_w;
    logic run_w, err_ie_w, busy_w, accept_w, stop_w, cmp_w, err_w;

    assign sel_lo   = (reg_addr == ADDR_W'(OFS_BASE_LO));
    assign sel_hi   = (reg_addr == ADDR_W'(OFS_BASE_HI));
    assign sel_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
    assign sel_stat = (reg_addr == ADDR_W'(OFS_STAT));
    assign sel_size = (reg_addr == ADDR_W'(OFS_SIZE));

    assign wr_lo_w   = reg_wr && sel_lo;
    assign wr_hi_w   = reg_wr && sel_hi;
    assign wr_ctrl_w = reg_wr && sel_ctrl;
    assign wr_stat_w = reg_wr && sel_stat;
    assign wr_size_w = reg_wr && sel_size;
    assign clr_cmp_w = wr_stat_w && reg_wdata[STAT_CMP_BIT];
    assign clr_err_w = wr_stat_w && reg_wdata[STAT_ERR_BIT];

    drc_cfg_regs #(.BASE_W(BASE_W), .PTR_W(PTR_W)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_base_lo (wr_lo_w),
        .wr_base_hi (wr_hi_w),
        .wr_ctrl    (wr_ctrl_w),
        .wr_size    (wr_size_w),
        .wdata      (reg_wdata),
        .stop_run   (stop_w),
        .base       (base_w),
        .head       (head_w),
        .size_m1    (size_w),
        .run        (run_w),
        .err_ie     (err_ie_w)
    );

    drc_ring_ptr #(.PTR_W(PTR_W)) ptr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_w),
        .head     (head_w),
        .size_m1  (size_w),
        .done     (eng_done),
        .tail     (tail_w),
        .busy     (busy_w),
        .accept   (accept_w),
        .stop_run (stop_w)
    );

    drc_irq_flags flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept_w),
        .want_irq (eng_want_irq),
        .fail     (eng_fail),
        .clr_cmp  (clr_cmp_w),
        .clr_err  (clr_err_w),
        .err_ie   (err_ie_w),
        .cmp      (cmp_w),
        .err      (err_w),
        .irq      (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_lo) begin
            reg_rdata = base_w[31:0];
        end else if (sel_hi) begin
            reg_rdata = 32'(base_w[BASE_W-1:32]);
        end else if (sel_ctrl) begin
            reg_rdata[CTRL_RUN_BIT] = run_w;
            reg_rdata[CTRL_EIE_BIT] = err_ie_w;
            reg_rdata[PTR_LSB +: PTR_FIELD_W] = PTR_FIELD_W'(head_w);
        end else if (sel_stat) begin
            reg_rdata[STAT_BUSY_BIT] = busy_w;
            reg_rdata[STAT_ERR_BIT]  = err_w;
            reg_rdata[STAT_CMP_BIT]  = cmp_w;
            reg_rdata[PTR_LSB +: PTR_FIELD_W] = PTR_FIELD_W'(tail_w);
        end else if (sel_size) begin
            reg_rdata[PTR_FIELD_W-1:0] = PTR_FIELD_W'(size_w);
        end
    end

    assign eng_base = base_w;
    assign eng_req  = busy_w;
    assign eng_idx  = tail_w;
endmodule

// File: rtl/drc_chk.sv
module drc_chk #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             stat_wr,
    input logic             clr_cmp,
    input logic             eng_req,
    input logic             eng_done,
    input logic [PTR_W-1:0] eng_idx,
    input logic             irq,
    input logic [PTR_W-1:0] head,
    input logic [PTR_W-1:0] tail,
    input logic [PTR_W-1:0] size_m1,
    input logic             run,
    input logic             err_ie,
    input logic             cmp,
    input logic             err
);
    // R6
    tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_req && eng_done) |=> $stable(tail));

    // R4
    tail_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_done && tail == size_m1) |=> (tail == '0));

    // R5
    idx_not_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> (eng_idx != head));

    // R7
    run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tail == head && !ctrl_wr) |=> !run);

    // R9
    cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmp && !(eng_req && eng_done)) |=> !cmp);

    // R8
    cmp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp && !stat_wr) |=> cmp);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_ie |-> !irq);

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cmp || err));
endmodule

bind desc_ring_ctrl drc_chk #(.PTR_W(PTR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (wr_ctrl_w),
    .stat_wr  (wr_stat_w),
    .clr_cmp  (clr_cmp_w),
    .eng_req  (eng_req),
    .eng_done (eng_done),
    .eng_idx  (eng_idx),
    .irq      (irq),
    .head     (head_w),
    .tail     (tail_w),
    .size_m1  (size_w),
    .run      (run_w),
    .err_ie   (err_ie_w),
    .cmp      (cmp_w),
    .err      (err_w)
);

// File: tb/desc_ring_ctrl_tb_top.sv
`timescale 1ns/1ps
module desc_ring_ctrl_tb_top;
    localparam int ADDR_W = 12;
    localparam int BASE_W = 64;
    localparam int PTR_W  = 8;

    localparam int K_RD   = 0;
    localparam int K_REQ  = 1;
    localparam int K_IDX  = 2;
    localparam int K_IRQ  = 3;
    localparam int K_BLO  = 4;
    localparam int K_BHI  = 5;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [BASE_W-1:0] eng_base;
    logic              eng_req;
    logic [PTR_W-1:0]  eng_idx;
    logic              eng_done = 1'b0;
    logic              eng_want_irq = 1'b0;
    logic              eng_fail = 1'b0;
    logic              irq;

    item_t exp_q[$];
    event  chk_ev;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;

    always #2.5 clk = ~clk;

    desc_ring_ctrl #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .PTR_W(PTR_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .eng_base     (eng_base),
        .eng_req      (eng_req),
        .eng_idx      (eng_idx),
        .eng_done     (eng_done),
        .eng_want_irq (eng_want_irq),
        .eng_fail     (eng_fail),
        .irq          (irq)
    );

    // Monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = exp_q.pop_front();
                case (it.kind)
                    K_RD:    act = reg_rdata;
                    K_REQ:   act = 32'(eng_req);
                    K_IDX:   act = 32'(eng_idx);
                    K_IRQ:   act = 32'(irq);
                    K_BLO:   act = eng_base[31:0];
                    default: act = eng_base[63:32];
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver side: push one expected item, let the monitor compare, realign
    task automatic expect_val(input int kind, input logic [ADDR_W-1:0] a,
                              input logic [31:0] e, input string tag);
        item_t it;
        if (kind == K_RD) reg_addr = a;
        #1;
        it.kind = kind;
        it.exp  = e;
        it.tag  = tag;
        exp_q.push_back(it);
        ->chk_ev;
        @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic done_pulse(input logic want, input logic fail);
        eng_done = 1'b1; eng_want_irq = want; eng_fail = fail;
        @(negedge clk);
        eng_done = 1'b0; eng_want_irq = 1'b0; eng_fail = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_val(K_RD, 12'h100, 32'h0, "R1 base lo");
        expect_val(K_RD, 12'h104, 32'h0, "R1 base hi");
        expect_val(K_RD, 12'h108, 32'h0, "R1 ctrl");
        expect_val(K_RD, 12'h10C, 32'h0, "R1 status");
        expect_val(K_RD, 12'h110, 32'h0, "R1 size");
        expect_val(K_REQ, '0, 32'h0, "R1 req");
        expect_val(K_IRQ, '0, 32'h0, "R1 irq");

        // R2 base address
        wr(12'h100, 32'h89AB_CDEF);
        wr(12'h104, 32'h0123_4567);
        expect_val(K_RD, 12'h100, 32'h89AB_CDEF, "R2 base lo read");
        expect_val(K_RD, 12'h104, 32'h0123_4567, "R2 base hi read");
        expect_val(K_BLO, '0, 32'h89AB_CDEF, "R2 eng_base lo");
        expect_val(K_BHI, '0, 32'h0123_4567, "R2 eng_base hi");

        // R3/R5 start a run of three descriptors on a four-entry ring
        wr(12'h110, 32'h3);
        expect_val(K_RD, 12'h110, 32'h3, "R4 size read");
        wr(12'h108, 32'h0003_0011);
        expect_val(K_RD, 12'h108, 32'h0003_0011, "R3 ctrl read");
        expect_val(K_REQ, '0, 32'h1, "R5 req high");
        expect_val(K_IDX, '0, 32'h0, "R5 idx 0");
        expect_val(K_RD, 12'h10C, 32'h0000_0001, "R5 busy");

        // R6/R8/R10 completions
        done_pulse(1'b0, 1'b0);
        expect_val(K_IDX, '0, 32'h1, "R6 idx 1");
        expect_val(K_IRQ, '0, 32'h0, "R10 no flag no irq");
        done_pulse(1'b1, 1'b0);
        expect_val(K_IDX, '0, 32'h2, "R6 idx 2");
        expect_val(K_RD, 12'h10C, 32'h0002_0021, "R8 cmp set");
        expect_val(K_IRQ, '0, 32'h1, "R10 irq on cmp");
        done_pulse(1'b0, 1'b1);
        // R7 drained
        expect_val(K_REQ, '0, 32'h0, "R7 req low");
        expect_val(K_RD, 12'h10C, 32'h0003_0030, "R7 R8 status drained");
        expect_val(K_RD, 12'h108, 32'h0003_0010, "R7 start cleared");

        // R6 done while idle ignored
        done_pulse(1'b1, 1'b1);
        expect_val(K_RD, 12'h10C, 32'h0003_0030, "R6 idle done ignored");

        // R9 write-one-to-clear
        wr(12'h10C, 32'h0);
        expect_val(K_RD, 12'h10C, 32'h0003_0030, "R9 zero write keeps");
        wr(12'h10C, 32'h20);
        expect_val(K_RD, 12'h10C, 32'h0003_0010, "R9 cmp cleared");
        expect_val(K_IRQ, '0, 32'h1, "R10 irq on err");
        wr(12'h10C, 32'h10);
        expect_val(K_RD, 12'h10C, 32'h0003_0000, "R9 err cleared");
        expect_val(K_IRQ, '0, 32'h0, "R10 irq low");

        // R4 wrap, R10 enable off
        wr(12'h108, 32'h0001_0001);
        expect_val(K_IDX, '0, 32'h3, "R5 idx 3");
        done_pulse(1'b0, 1'b0);
        expect_val(K_IDX, '0, 32'h0, "R4 wrap to 0");
        done_pulse(1'b1, 1'b0);
        expect_val(K_RD, 12'h10C, 32'h0001_0020, "R4 R8 status after wrap");
        expect_val(K_IRQ, '0, 32'h0, "R10 gated off");

        // R11 pause and resume
        wr(12'h10C, 32'h20);
        wr(12'h108, 32'h0003_0001);
        expect_val(K_IDX, '0, 32'h1, "R11 idx 1");
        done_pulse(1'b0, 1'b0);
        wr(12'h108, 32'h0003_0000);
        expect_val(K_REQ, '0, 32'h0, "R11 paused");
        done_pulse(1'b0, 1'b0);
        expect_val(K_RD, 12'h10C, 32'h0002_0000, "R11 tail kept");
        wr(12'h108, 32'h0003_0001);
        expect_val(K_REQ, '0, 32'h1, "R11 resumed");
        expect_val(K_IDX, '0, 32'h2, "R11 resume idx");
        done_pulse(1'b0, 1'b0);
        expect_val(K_RD, 12'h10C, 32'h0003_0000, "R11 drained");

        // R9 set wins over clear on the same edge, with wrap (R4)
        wr(12'h108, 32'h0000_0001);
        expect_val(K_IDX, '0, 32'h3, "R5 idx 3 again");
        reg_wr = 1'b1; reg_addr = 12'h10C; reg_wdata = 32'h20;
        eng_done = 1'b1; eng_want_irq = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; eng_done = 1'b0; eng_want_irq = 1'b0;
        expect_val(K_RD, 12'h10C, 32'h0000_0020, "R9 set wins");

        // R12 unmapped offset
        wr(12'h114, 32'hFFFF_FFFF);
        expect_val(K_RD, 12'h114, 32'h0, "R12 unmapped read");
        expect_val(K_RD, 12'h108, 32'h0, "R12 ctrl untouched");
        expect_val(K_RD, 12'h110, 32'h3, "R12 size untouched");

        // R7 start written while tail equals head
        wr(12'h108, 32'h0000_0011);
        expect_val(K_REQ, '0, 32'h0, "R7 no req when equal");
        expect_val(K_RD, 12'h108, 32'h0000_0010, "R7 start self-cleared");
        expect_val(K_IRQ, '0, 32'h1, "R10 irq with enable");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule